// File: doc/BRIEF.md
# Grouped Flag Bit Set/Clear Unit

This unit holds sixteen single-bit software flags and updates one of them per accepted opcode. An 8-bit opcode arrives with a valid strobe. Its upper nibble selects the operation, and its lower nibble names the flag to write. A set opcode forces the addressed flag to 1, and a clear opcode forces it to 0.

The flags are grouped in fours. After every set or clear, the unit recomputes a zero flag from the group that holds the addressed bit, after the write has been applied. The zero flag is not taken from the addressed bit alone. Software can therefore test a whole group of four flags with one set or clear. The full flag vector and the zero flag are registered outputs. Both reflect an accepted opcode at the clock edge that samples it.

Top module: `flag_group_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all sixteen flags and the zero flag at that edge, even when a valid opcode is presented in the same cycle.
- R2: With `opValid` high, opcode `0101_iiii` sets flag F[iiii] to 1 at the sampling edge.
- R3: With `opValid` high, opcode `0001_iiii` clears flag F[iiii] to 0 at the sampling edge.
- R4: A set or clear changes no flag other than the addressed one.
- R5: After a set or clear, `zeroFlag` is 1 exactly when all four bits of the addressed flag's group are 0 after the write. The groups are F0–F3, F4–F7, F8–F11 and F12–F15, so group number = iiii[3:2].
- R6: When `opValid` is low, or when the upper nibble is neither `0101` nor `0001`, the flags and `zeroFlag` keep their values.
- R7: A set of a flag that is already 1, or a clear of a flag that is already 0, leaves the vector unchanged but still recomputes `zeroFlag` from the addressed group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Opcode strobe |
| opCode | input | 8 | Opcode: operation class in [7:4], flag index in [3:0] |
| flags | output | 16 | Current flag vector, bit n is Fn |
| zeroFlag | output | 1 | Group-zero result of the last set or clear |

## Verification
The bench builds the unit with its default parameters: sixteen flags split into groups of four. Every flag index, and the zero result of all four groups, is therefore reachable from plain opcode sequences. The stimulus fills the vector, drains whole groups, and repeats writes that change no bit, so that the zero flag must flip without any flag changing. It also sends invalid-class opcodes and a reset that collides with a valid opcode.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int IDX_W      = 4;
  localparam int FLAG_COUNT = 1 << IDX_W;
  localparam int OP_W       = 8;
  localparam int CLS_W      = OP_W - IDX_W;

  localparam logic [CLS_W-1:0] CLS_SET   = 4'b0101;
  localparam logic [CLS_W-1:0] CLS_CLEAR = 4'b0001;

  typedef struct packed {
    logic             wrEn;
    logic             wrVal;
    logic [IDX_W-1:0] idx;
  } flagStrobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output flagStrobe_t     strobe
);
  logic [CLS_W-1:0] opClass;

  assign opClass = opCode[OP_W-1:IDX_W];

  always_comb begin
    strobe       = '0;
    strobe.idx   = opCode[IDX_W-1:0];
    if (opValid) begin
      if (opClass == CLS_SET) begin
        strobe.wrEn  = 1'b1;
        strobe.wrVal = 1'b1;
      end else if (opClass == CLS_CLEAR) begin
        strobe.wrEn  = 1'b1;
        strobe.wrVal = 1'b0;
      end
    end
  end
endmodule

// File: rtl/flag_dp.sv
module flag_dp
  import flag_pkg::*;
#(
  parameter int GROUP_SIZE = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  flagStrobe_t           strobe,
  output logic [FLAG_COUNT-1:0] flagQ,
  output logic                  zfQ
);
  localparam int GROUP_CNT = FLAG_COUNT / GROUP_SIZE;
  localparam int GRP_W     = $clog2(GROUP_SIZE);

  logic [FLAG_COUNT-1:0]  flagNext;
  logic [GROUP_CNT-1:0]   grpZero;
  logic [IDX_W-GRP_W-1:0] grpSel;

  assign grpSel = strobe.idx[IDX_W-1:GRP_W];

  always_comb begin
    flagNext = flagQ;
    if (strobe.wrEn) flagNext[strobe.idx] = strobe.wrVal;
  end

  for (genvar g = 0; g < GROUP_CNT; g++) begin : gGroup
    assign grpZero[g] = ~|flagNext[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= '0;
      zfQ   <= 1'b0;
    end else if (strobe.wrEn) begin
      flagQ <= flagNext;
      zfQ   <= grpZero[grpSel];
    end
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn && strobe.wrVal |=> flagQ[$past(strobe.idx)] == 1'b1); // R2
  AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn && !strobe.wrVal |=> flagQ[$past(strobe.idx)] == 1'b0); // R3
  AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> $countones(flagQ ^ $past(flagQ)) <= 1); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrEn |=> $stable(flagQ) && $stable(zfQ)); // R6
endmodule

// File: rtl/flag_group_unit.sv
module flag_group_unit
  import flag_pkg::*;
#(
  parameter int GROUP_SIZE = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  opValid,
  input  logic [OP_W-1:0]       opCode,
  output logic [FLAG_COUNT-1:0] flags,
  output logic                  zeroFlag
);
  flagStrobe_t strobe;

  flag_ctrl ctrl_i (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  flag_dp #(.GROUP_SIZE(GROUP_SIZE)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .flagQ  (flags),
    .zfQ    (zeroFlag)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> flags == '0 && !zeroFlag); // R1
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    opValid && opCode[OP_W-1:IDX_W] != CLS_SET && opCode[OP_W-1:IDX_W] != CLS_CLEAR
      |=> $stable(flags) && $stable(zeroFlag)); // R6
endmodule

// File: tb/flag_group_unit_tb_top.sv
`timescale 1ns/100ps
module flag_group_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [7:0]  opCode = 8'h00;
  logic [15:0] flags;
  logic        zeroFlag;

  always #2.5 clk = ~clk;

  flag_group_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .opValid  (opValid),
    .opCode   (opCode),
    .flags    (flags),
    .zeroFlag (zeroFlag)
  );

  typedef struct {
    logic [15:0] f;
    logic        z;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [15:0] mFlags = '0;
  logic        mZero = 1'b0;

  task automatic drive(input logic r, input logic v, input logic [7:0] op, input string tag);
    @(negedge clk);
    rst = r; opValid = v; opCode = op;
    if (r) begin
      mFlags = '0; mZero = 1'b0;
    end else if (v && (op[7:4] == 4'b0101 || op[7:4] == 4'b0001)) begin
      mFlags[op[3:0]] = (op[7:4] == 4'b0101);
      mZero = (mFlags[{op[3:2], 2'b00} +: 4] == 4'b0000);
    end
    expQ.push_back('{mFlags, mZero, tag});
  endtask

  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (flags !== e.f || zeroFlag !== e.z) begin
        fails++;
        $display("FAIL %s: flags=%h zf=%b expected flags=%h zf=%b", e.tag, flags, zeroFlag, e.f, e.z);
      end
    end
  end

  initial begin
    // R1: reset wins over a colliding set opcode
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 8'h55, "R1");
    // R2, R5: fill every flag
    for (int i = 0; i < 16; i++) drive(1'b0, 1'b1, {4'b0101, 4'(i)}, "R2");
    // R3, R4, R5: drain group 0
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, {4'b0001, 4'(i)}, "R3");
    // R7: clear of an already-clear flag keeps ZF from group 0
    drive(1'b0, 1'b1, 8'h12, "R7");
    // R7: set of an already-set flag in group 1 drives ZF low
    drive(1'b0, 1'b1, 8'h55, "R7");
    // R6: foreign classes and idle strobe
    drive(1'b0, 1'b1, 8'h00, "R6");
    drive(1'b0, 1'b1, 8'hFF, "R6");
    drive(1'b0, 1'b1, 8'h2C, "R6");
    drive(1'b0, 1'b1, 8'hD3, "R6");
    drive(1'b0, 1'b0, 8'h1A, "R6");
    drive(1'b0, 1'b0, 8'h57, "R6");
    // R5: drain group 3 from the top down
    for (int i = 15; i >= 12; i--) drive(1'b0, 1'b1, {4'b0001, 4'(i)}, "R5");
    // R4: clear in group 2 touches only F9
    drive(1'b0, 1'b1, 8'h19, "R4");
    // R1: mid-run reset with a clear opcode
    drive(1'b1, 1'b1, 8'h14, "R1");
    drive(1'b0, 1'b1, 8'h57, "R2");
    drive(1'b0, 1'b1, 8'h17, "R3");
    drive(1'b0, 1'b1, 8'h5A, "R5");
    drive(1'b0, 1'b1, 8'h18, "R7");
    drive(1'b0, 1'b0, 8'h00, "R6");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule